// File: doc/BRIEF.md
# Bidirectional I/O Port with Clock-Output Takeover

This block is a five-pin general-purpose I/O port attached to a simple 8-bit peripheral bus. It has two registers. The pin data register holds the output latches. The pin direction register sets each pin's output driver and also carries a takeover bit that hands one pin to a clock output. Software picks a direction for each pin on its own, preloads output values, and reads back a mix of latched values and sampled pin levels.

Each pin has an output value, an output enable and an input level. Input levels pass through a synchroniser before they reach the read path. When the takeover bit is set, the selected pin drives the clock source input with its driver forced on, whatever its direction bit and latch hold. All widths, offsets, the takeover pin, the takeover bit position and the synchroniser depth are parameters.

Top module: `clkgpio_port`

## Requirements
- R1: After reset every direction bit, every output latch and the takeover bit are 0: `pin_oe` is 0, `pin_out` is 0, and both registers read as 0x00.
- R2: A write to the direction register (offset 0x06) sets `pin_oe[i]` to write-data bit i for pins 0..4 from the next rising edge. A 1 enables the driver and a 0 makes the pin an input.
- R3: A write to the data register (offset 0x02) loads write-data bits 4:0 into the output latches, and `pin_out` shows them, whether or not the pins are outputs. This allows a value to be preloaded before the direction is switched.
- R4: A read of the data register returns the latch value in bit i for each pin whose direction bit is 1.
- R5: A read of the data register returns the synchronised pin level in bit i for each pin whose direction bit is 0. A level change shows up on reads after exactly two rising edges.
- R6: A read of the direction register returns the takeover bit in bit 7, zeros in bits 6:5 and the direction bits in bits 4:0. Writes to bits 6:5 have no effect.
- R7: While the takeover bit (direction register bit 7) is 1, `pin_oe[2]` is 1 and `pin_out[2]` follows `clk_src`, whatever direction bit 2 and latch bit 2 hold.
- R8: While the takeover bit is 1, bit 2 of a data-register read returns the synchronised level of pin 2.
- R9: Bits 7:5 of a data-register read are always 0.
- R10: `bus_rdata` is 0 when `bus_rd` is low or the address matches neither register. Writes to unmapped addresses change no register.
- R11: Register contents change only on a rising edge with `bus_wr` high and a matching address. A matching address with `bus_wr` low leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when idle or unmapped |
| clk_src | input | 1 | Clock routed to pin 2 during takeover |
| pin_out | output | 5 | Per-pin output value |
| pin_oe | output | 5 | Per-pin output enable |
| pin_in | input | 5 | Per-pin input level |

## Verification
A register write takes effect at the rising edge where the strobe is seen. The bench drives the write at a falling edge and checks `pin_out`, `pin_oe` or a readback only after the following rising edge. Reads are combinational, so they are sampled 1 ns after the address and strobe are driven, in the same cycle and well before the next edge. A pin level change is due on reads two rising edges after it is applied. The bench therefore checks it once after the first edge, expecting the old value, and once after the second, expecting the new one. Before any other read that depends on pin levels, the bench lets at least three edges pass.

// File: rtl/clkgpio_pkg.sv
package clkgpio_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [7:0] addr,
                                           input logic [7:0] data_ofs,
                                           input logic [7:0] dir_ofs);
      if (addr == data_ofs)     return SEL_DATA;
      else if (addr == dir_ofs) return SEL_DIR;
      else                      return SEL_NONE;
   endfunction
endpackage

// File: rtl/clkgpio_sync.sv
module clkgpio_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("clkgpio_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/clkgpio_regs.sv
module clkgpio_regs
   import clkgpio_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          NUM_PINS  = 5,
   parameter int          CLK_PIN   = 2,
   parameter int          CLKEN_BIT = 7,
   parameter logic [7:0]  DATA_OFS  = 8'h02,
   parameter logic [7:0]  DIR_OFS   = 8'h06
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [NUM_PINS-1:0] latch_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic                clken_q
);
   localparam logic [NUM_PINS-1:0] CLK_MASK = NUM_PINS'(1) << CLK_PIN;

   reg_sel_e sel;
   logic     wr_data, wr_dir;

   assign sel     = decode_sel(bus_addr, DATA_OFS, DIR_OFS);
   assign wr_data = bus_wr && (sel == SEL_DATA);
   assign wr_dir  = bus_wr && (sel == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr_data) begin
         latch_q <= bus_wdata[NUM_PINS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         clken_q <= 1'b0;
      end else if (wr_dir) begin
         dir_q   <= bus_wdata[NUM_PINS-1:0];
         clken_q <= bus_wdata[CLKEN_BIT];
      end
   end

   logic [NUM_PINS-1:0] from_pin;
   logic [DATA_W-1:0]   data_view, dir_view;

   assign from_pin = ~dir_q | (clken_q ? CLK_MASK : '0);

   always_comb begin
      data_view                 = '0;
      data_view[NUM_PINS-1:0]   = (latch_q & ~from_pin) | (pin_sync & from_pin);
      dir_view                  = '0;
      dir_view[NUM_PINS-1:0]    = dir_q;
      dir_view[CLKEN_BIT]       = clken_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_DATA: bus_rdata = data_view;
            SEL_DIR:  bus_rdata = dir_view;
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/clkgpio_pinmux.sv
module clkgpio_pinmux #(
   parameter int NUM_PINS = 5,
   parameter int CLK_PIN  = 2
) (
   input  logic [NUM_PINS-1:0] latch_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic                clken_q,
   input  logic                clk_src,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   genvar i;
   generate
      for (i = 0; i < NUM_PINS; i++) begin : g_pin
         if (i == CLK_PIN) begin : g_takeover
            assign pin_out[i] = clken_q ? clk_src : latch_q[i];
            assign pin_oe[i]  = dir_q[i] | clken_q;
         end else begin : g_plain
            assign pin_out[i] = latch_q[i];
            assign pin_oe[i]  = dir_q[i];
         end
      end
   endgenerate
endmodule

// File: rtl/clkgpio_port.sv
module clkgpio_port #(
   parameter int         DATA_W      = 8,
   parameter int         NUM_PINS    = 5,
   parameter int         CLK_PIN     = 2,
   parameter int         CLKEN_BIT   = 7,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] DATA_OFS    = 8'h02,
   parameter logic [7:0] DIR_OFS     = 8'h06
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                clk_src,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_PINS-1:0] pin_in
);
   generate
      if (NUM_PINS < 1 || NUM_PINS >= DATA_W) begin : g_bad_pins
         $error("clkgpio_port: NUM_PINS must lie in 1..DATA_W-1");
      end
      if (CLK_PIN < 0 || CLK_PIN >= NUM_PINS) begin : g_bad_clkpin
         $error("clkgpio_port: CLK_PIN must name an existing pin");
      end
      if (CLKEN_BIT < NUM_PINS || CLKEN_BIT >= DATA_W) begin : g_bad_clkbit
         $error("clkgpio_port: CLKEN_BIT must sit above the direction bits");
      end
      if (DATA_OFS == DIR_OFS) begin : g_bad_ofs
         $error("clkgpio_port: register offsets must differ");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_sync, latch_q, dir_q;
   logic                clken_q;

   clkgpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   clkgpio_regs #(
      .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .CLK_PIN(CLK_PIN),
      .CLKEN_BIT(CLKEN_BIT), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .latch_q   (latch_q),
      .dir_q     (dir_q),
      .clken_q   (clken_q)
   );

   clkgpio_pinmux #(.NUM_PINS(NUM_PINS), .CLK_PIN(CLK_PIN)) u_mux (
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .clken_q (clken_q),
      .clk_src (clk_src),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );
endmodule

// File: rtl/clkgpio_port_chk.sv
module clkgpio_port_chk #(
   parameter int         DATA_W    = 8,
   parameter int         NUM_PINS  = 5,
   parameter int         CLK_PIN   = 2,
   parameter int         CLKEN_BIT = 7,
   parameter logic [7:0] DATA_OFS  = 8'h02,
   parameter logic [7:0] DIR_OFS   = 8'h06
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                clk_src,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe
);
   localparam logic [NUM_PINS-1:0] CLK_MASK = NUM_PINS'(1) << CLK_PIN;
   localparam logic [DATA_W-1:0]   DIR_USED =
      ((DATA_W'(1) << NUM_PINS) - DATA_W'(1)) | (DATA_W'(1) << CLKEN_BIT);
   localparam logic [DATA_W-1:0]   DATA_USED = (DATA_W'(1) << NUM_PINS) - DATA_W'(1);

   // R2: direction write drives output enables of ordinary pins
   a_r2_dir_write_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_OFS) |=>
         ((pin_oe & ~CLK_MASK) == ($past(bus_wdata[NUM_PINS-1:0]) & ~CLK_MASK)));

   // R3: data write reaches the latched outputs even for input pins
   a_r3_data_write_out: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_OFS) |=>
         ((pin_out & ~CLK_MASK) == ($past(bus_wdata[NUM_PINS-1:0]) & ~CLK_MASK)));

   // R6: gap bits of the direction register read as zero
   a_r6_dir_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DIR_OFS) |-> ((bus_rdata & ~DIR_USED) == '0));

   // R7: takeover reported on readback means the pin carries the clock
   a_r7_takeover_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DIR_OFS && bus_rdata[CLKEN_BIT]) |->
         (pin_oe[CLK_PIN] && pin_out[CLK_PIN] == clk_src));

   // R9: data register upper bits read as zero
   a_r9_data_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DATA_OFS) |-> ((bus_rdata & ~DATA_USED) == '0));

   // R10: idle or unmapped reads return zero
   a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || (bus_addr != DATA_OFS && bus_addr != DIR_OFS)) |-> (bus_rdata == '0));

   // R11: without a write strobe the enables hold
   a_r11_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_oe));
endmodule

bind clkgpio_port clkgpio_port_chk #(
   .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .CLK_PIN(CLK_PIN),
   .CLKEN_BIT(CLKEN_BIT), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .clk_src(clk_src), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/clkgpio_port_test.sv
`timescale 1ns/1ps
module clkgpio_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       clk_src = 1'b0;
   logic [4:0] pin_out, pin_oe;
   logic [4:0] pin_in = 5'b10110;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clkgpio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .clk_src(clk_src), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
   );

   localparam logic [7:0] A_DATA = 8'h02;
   localparam logic [7:0] A_DIR  = 8'h06;
   localparam int NVEC = 16;
   // {write, address, write data, expected read data}; pins held at 5'b10110
   localparam logic [24:0] VEC [NVEC] = '{
      {1'b0, 8'h02, 8'h00, 8'h16},  // R5 all inputs
      {1'b1, 8'h02, 8'hFF, 8'h00},
      {1'b0, 8'h02, 8'h00, 8'h16},  // R5 latch hidden while input
      {1'b1, 8'h06, 8'h0F, 8'h00},
      {1'b0, 8'h06, 8'h00, 8'h0F},  // R6
      {1'b0, 8'h02, 8'h00, 8'h1F},  // R4 latch on outputs, pin on bit 4
      {1'b1, 8'h02, 8'h00, 8'h00},
      {1'b0, 8'h02, 8'h00, 8'h10},  // R4 R9
      {1'b1, 8'h06, 8'hFF, 8'h00},
      {1'b0, 8'h06, 8'h00, 8'h9F},  // R6 gap bits ignored
      {1'b1, 8'h06, 8'h60, 8'h00},
      {1'b0, 8'h06, 8'h00, 8'h00},  // R6
      {1'b0, 8'h03, 8'h00, 8'h00},  // R10 unmapped read
      {1'b1, 8'h04, 8'hFF, 8'h00},
      {1'b0, 8'h06, 8'h00, 8'h00},  // R10 unmapped write ignored
      {1'b0, 8'h02, 8'h00, 8'h16}   // R10
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk);
      bus_addr = A_DIR; bus_rd = 1'b1;
      #1 check("R1 dir reads zero", bus_rdata, 8'h00);
      check("R1 oe zero", {3'b0, pin_oe}, 8'h00);
      check("R1 out zero", {3'b0, pin_out}, 8'h00);
      bus_rd = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      for (int k = 0; k < NVEC; k++) begin
         if (VEC[k][24]) bus_write(VEC[k][23:16], VEC[k][15:8]);
         else begin
            bus_read(VEC[k][23:16], rd);
            check($sformatf("table entry %0d R4/R5/R6/R9/R10", k), rd, VEC[k][7:0]);
         end
      end

      // R3: preload while input, then switch direction
      bus_write(A_DATA, 8'h04);
      #1 check("R3 preload out", {3'b0, pin_out}, 8'h04);
      check("R3 still input", {3'b0, pin_oe}, 8'h00);
      bus_write(A_DIR, 8'h04);
      #1 check("R2 oe set", {3'b0, pin_oe}, 8'h04);
      check("R3 out kept", {3'b0, pin_out}, 8'h04);

      // R11: address present without strobe
      @(negedge clk);
      bus_addr = A_DIR; bus_wdata = 8'h1B; bus_wr = 1'b0;
      @(negedge clk);
      bus_read(A_DIR, rd);
      check("R11 no strobe no change", rd, 8'h04);

      // R10: read strobe low
      @(negedge clk);
      bus_addr = A_DIR; bus_rd = 1'b0;
      #1 check("R10 idle read", bus_rdata, 8'h00);

      // R5: two-edge latency
      bus_write(A_DIR, 8'h00);
      @(negedge clk);
      pin_in = 5'b01001;
      @(posedge clk);
      bus_addr = A_DATA; bus_rd = 1'b1;
      #1 check("R5 not yet after one edge", bus_rdata, 8'h16);
      @(posedge clk);
      #1 check("R5 visible after two edges", bus_rdata, 8'h09);
      bus_rd = 1'b0;

      // R7/R8: takeover with dir bit 2 = 0 and latch bit 2 = 0
      bus_write(A_DATA, 8'h00);
      bus_write(A_DIR, 8'h80);
      @(negedge clk);
      clk_src = 1'b1;
      #1 check("R7 oe forced", {3'b0, pin_oe}, 8'h04);
      check("R7 out high", {3'b0, pin_out}, 8'h04);
      clk_src = 1'b0;
      #1 check("R7 out low", {3'b0, pin_out}, 8'h00);
      bus_write(A_DIR, 8'h84);
      @(negedge clk);
      pin_in = 5'b00100;
      repeat (3) @(posedge clk);
      bus_read(A_DATA, rd);
      check("R8 pin level on bit 2", rd, 8'h04);
      bus_write(A_DIR, 8'h04);
      bus_read(A_DATA, rd);
      check("R4 latch back after takeover off", rd, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule